// File: doc/BRIEF.md
# Programmable Edge-Action Counter

This block watches a few digital lines and turns their transitions into counting or bit-setting actions. Each line can be marked as sensitive, as a modifier, or both. A rising or falling transition on a sensitive line looks up a 2-bit action code. The code is chosen from a small table by three things: which line moved, the direction of the move, and the current levels of the other lines that are marked as modifiers. The action then steps an up/down accumulator or sets or clears a single output bit.

The table is written through a small configuration write port, one 4-bit entry per address. The line roles and the counting or bit mode are static inputs. A one-cycle strobe copies the accumulator into a separate output register, where it can be captured while counting goes on.

Top module: `edge_comb_accum`

## Requirements
- R1: While `rst` is high, `acc_q`, `bit_q` and `hold_q` are cleared to zero on each clock edge.
- R2: In counting mode (`bit_mode`=0), action 01 adds one to `acc_q` and action 10 subtracts one, and `bit_q` is left unchanged. When a `din` change is driven just after a clock edge, the result is visible after the third rising edge that follows, because of two synchroniser flops and one previous-value flop.
- R3: Action 00 and the reserved action 11 change neither `acc_q` nor `bit_q`.
- R4: Each table entry holds the rising-edge code in bits [1:0] and the falling-edge code in bits [3:2].
- R5: The table address is {line index, state}. The state holds the other NUM_IN-1 lines in ascending index order, with the lowest index in the LSB. Each of these lines reads as its level if its `mod_mask` bit is 1, and as 0 otherwise. The levels used are those from before the edge.
- R6: A line whose `sens_mask` and `mod_mask` bits are both set counts on its own edges and also selects the state used for the other lines.
- R7: Edges on a line whose `sens_mask` bit is 0 cause no action.
- R8: In bit mode (`bit_mode`=1), action 01 sets `bit_q` and action 10 clears it, and `acc_q` does not change.
- R9: `acc_q` wraps modulo 2^ACC_W in both directions.
- R10: `hold_q` takes the value `acc_q` had during a cycle in which `latch_in` is high. At all other times `hold_q` keeps its value.
- R11: When edges arrive on several sensitive lines in the same cycle, only the lowest-indexed one acts and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | ADDR_W | Table address {line index, state} |
| cfg_data | input | 4 | Entry: fall code [3:2], rise code [1:0] |
| sens_mask | input | NUM_IN | Lines whose edges act |
| mod_mask | input | NUM_IN | Lines that take part in the state |
| bit_mode | input | 1 | 1 selects bit output, 0 selects accumulator |
| latch_in | input | 1 | Copy strobe for the accumulator |
| din | input | NUM_IN | Asynchronous input lines |
| acc_q | output | ACC_W | Accumulator |
| bit_q | output | 1 | Single output bit |
| hold_q | output | ACC_W | Latched accumulator copy |

## Verification
The hardest case to reach from the ports is an edge whose table entry depends on a modifier line that is masked off. Here a wrong state would still give a plausible count. The stimulus fills the unused table slots with opposite-direction codes, then moves a sensitive line while an unmasked, non-modifier line is high, so that any leak into the address reverses the count. Simultaneous edges are produced by changing two `din` bits in the same cycle. The lines are chosen so that the two lines carry different codes, which makes the choice of winner visible on `acc_q`.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_UP   = 2'b01,
    ACT_DOWN = 2'b10,
    ACT_RSVD = 2'b11
  } act_e;
endpackage

// File: rtl/cm_sync_edge.sv
module cm_sync_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] prev_q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/cm_code_table.sv
module cm_code_table #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [3:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [3:0]        rdata
);
  localparam int DEPTH = 2 ** ADDR_W;
  logic [3:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cm_edge_select.sv
module cm_edge_select #(
  parameter int NUM_IN = 3,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int ST_W  = NUM_IN - 1
) (
  input  logic [NUM_IN-1:0] rise,
  input  logic [NUM_IN-1:0] fall,
  input  logic [NUM_IN-1:0] level,
  input  logic [NUM_IN-1:0] sens_mask,
  input  logic [NUM_IN-1:0] mod_mask,
  output logic              hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic              win_rise,
  output logic [ST_W-1:0]   win_state
);
  logic [NUM_IN-1:0]            ev;
  logic [NUM_IN-1:0]            lvl_m;
  logic [NUM_IN-1:0][ST_W-1:0]  st_arr;

  assign ev    = (rise | fall) & sens_mask;
  assign lvl_m = level & mod_mask;
  assign hit   = |ev;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    for (genvar j = 0; j < NUM_IN; j++) begin : g_bit
      if (j < g) begin : g_lo
        assign st_arr[g][j] = lvl_m[j];
      end else if (j > g) begin : g_hi
        assign st_arr[g][j-1] = lvl_m[j];
      end
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (ev[i]) win_idx = IDX_W'(i);
    end
  end

  assign win_rise  = rise[win_idx];
  assign win_state = st_arr[win_idx];

  // R11: the chosen line has an edge and no lower line has one
  always_comb begin
    if (hit) begin
      p_lowest_wins_r11: assert (ev[win_idx] &&
        ((ev & ((NUM_IN'(1) << win_idx) - NUM_IN'(1))) == '0));
    end
  end
endmodule

// File: rtl/edge_comb_accum.sv
module edge_comb_accum #(
  parameter int NUM_IN = 3,
  parameter int ACC_W  = 8,
  localparam int IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int ST_W   = NUM_IN - 1,
  localparam int ADDR_W = IDX_W + ST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_data,
  input  logic [NUM_IN-1:0] sens_mask,
  input  logic [NUM_IN-1:0] mod_mask,
  input  logic              bit_mode,
  input  logic              latch_in,
  input  logic [NUM_IN-1:0] din,
  output logic [ACC_W-1:0]  acc_q,
  output logic              bit_q,
  output logic [ACC_W-1:0]  hold_q
);
  import cm_pkg::*;

  logic [NUM_IN-1:0] prev, rise, fall;
  logic              hit, win_rise;
  logic [IDX_W-1:0]  win_idx;
  logic [ST_W-1:0]   win_state;
  logic [3:0]        entry;
  act_e              code;

  cm_sync_edge #(.W(NUM_IN)) u_sync (
    .clk(clk), .rst(rst), .din(din),
    .prev_q(prev), .rise(rise), .fall(fall)
  );

  cm_edge_select #(.NUM_IN(NUM_IN)) u_sel (
    .rise(rise), .fall(fall), .level(prev),
    .sens_mask(sens_mask), .mod_mask(mod_mask),
    .hit(hit), .win_idx(win_idx), .win_rise(win_rise), .win_state(win_state)
  );

  cm_code_table #(.ADDR_W(ADDR_W)) u_tab (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_data),
    .raddr({win_idx, win_state}), .rdata(entry)
  );

  assign code = act_e'(win_rise ? entry[1:0] : entry[3:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      bit_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (latch_in) hold_q <= acc_q;
      if (hit) begin
        unique case (code)
          ACT_UP: begin
            if (bit_mode) bit_q <= 1'b1;
            else          acc_q <= acc_q + ACC_W'(1);
          end
          ACT_DOWN: begin
            if (bit_mode) bit_q <= 1'b0;
            else          acc_q <= acc_q - ACC_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !bit_q && (hold_q == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_mode |=> ((acc_q == $past(acc_q)) ||
                   (acc_q == $past(acc_q) + ACC_W'(1)) ||
                   (acc_q == $past(acc_q) - ACC_W'(1))) && $stable(bit_q));

  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && (code == ACT_RSVD || code == ACT_NONE)) |=> $stable(acc_q) && $stable(bit_q));

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(acc_q) && $stable(bit_q));

  p_bit_mode_r8: assert property (@(posedge clk) disable iff (rst)
    bit_mode |=> $stable(acc_q));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !latch_in |=> $stable(hold_q));
endmodule

// File: tb/edge_comb_accum_test.sv
`timescale 1ns/100ps
module edge_comb_accum_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [3:0] cfg_data = '0;
  logic [2:0] sens_mask = 3'b101;
  logic [2:0] mod_mask  = 3'b110;
  logic       bit_mode = 1'b0;
  logic       latch_in = 1'b0;
  logic [2:0] din = '0;
  logic [7:0] acc_q, hold_q;
  logic       bit_q;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  edge_comb_accum uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .sens_mask(sens_mask), .mod_mask(mod_mask), .bit_mode(bit_mode),
    .latch_in(latch_in), .din(din), .acc_q(acc_q), .bit_q(bit_q), .hold_q(hold_q)
  );

  // {din, expected acc}, each held for four clocks, counting mode
  localparam logic [10:0] VEC [22] = '{
    {3'b000, 8'd0}, {3'b001, 8'd1}, {3'b000, 8'd1}, {3'b001, 8'd2},
    {3'b000, 8'd2}, {3'b010, 8'd2}, {3'b011, 8'd1}, {3'b010, 8'd1},
    {3'b110, 8'd1}, {3'b111, 8'd1}, {3'b110, 8'd1}, {3'b100, 8'd1},
    {3'b101, 8'd2}, {3'b100, 8'd1}, {3'b101, 8'd2}, {3'b001, 8'd3},
    {3'b000, 8'd3}, {3'b100, 8'd4}, {3'b000, 8'd5}, {3'b010, 8'd5},
    {3'b110, 8'd5}, {3'b010, 8'd4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(logic [2:0] v);
    @(negedge clk) din = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk) cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", acc_q, 0);
    check("R1 bit", bit_q, 0);
    check("R1 hold", hold_q, 0);
    // line 0, state {in2,in1}: entries {fall,rise}
    wr(4'd0, 4'b0001);  // R4: rise up, fall none
    wr(4'd1, 4'b0010);  // rise down
    wr(4'd2, 4'b1001);  // rise up, fall down
    wr(4'd3, 4'b1111);  // R3: reserved both
    for (int a = 4; a < 8; a++) wr(4'(a), 4'b0101);  // line 1 not sensitive (R7)
    wr(4'd8,  4'b0101); // line 2 state {in1,in0}: 0 -> up both
    wr(4'd9,  4'b1010); // reachable only if in0 leaked into state (R5)
    wr(4'd10, 4'b1000); // rise none, fall down
    wr(4'd11, 4'b1010);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 table walk
    for (int k = 0; k < 22; k++) begin
      put(VEC[k][10:8]);
      check($sformatf("R2/R3/R5/R6/R7 vec%0d", k), acc_q, VEC[k][7:0]);
    end
    check("R2 bit untouched in counting mode", bit_q, 0);

    // R9 wrap down then up
    for (int k = 0; k < 5; k++) begin
      put(3'b011);
      put(3'b010);
    end
    check("R9 wrap down", acc_q, 255);
    put(3'b000);
    put(3'b001);
    check("R9 wrap up", acc_q, 0);

    // R8 bit mode
    put(3'b000);
    bit_mode = 1'b1;
    put(3'b001);
    check("R8 set bit", bit_q, 1);
    check("R8 acc frozen", acc_q, 0);
    put(3'b000);
    put(3'b010);
    put(3'b011);
    check("R8 clear bit", bit_q, 0);
    check("R8 acc frozen 2", acc_q, 0);
    put(3'b010);
    bit_mode = 1'b0;

    // R11 simultaneous edges, line 0 (down) beats line 2 (none)
    put(3'b111);
    check("R11 rise pair", acc_q, 255);
    put(3'b010);
    check("R11 fall pair line2 dropped", acc_q, 255);
    put(3'b000);
    put(3'b101);
    check("R11 single action", acc_q, 0);

    // R10 latch
    put(3'b100);
    check("R10 pre", acc_q, 255);
    @(negedge clk) latch_in = 1'b1;
    @(negedge clk) latch_in = 1'b0;
    check("R10 captured", hold_q, 255);
    put(3'b101);
    check("R10 acc moved", acc_q, 0);
    check("R10 hold kept", hold_q, 255);

    // R1 reset again
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 acc again", acc_q, 0);
    check("R1 hold again", hold_q, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule